// File: doc/BRIEF.md
# SHA-256 Compression Round Engine

This block performs one SHA-256 block compression. A start pulse loads eight 32-bit working variables from a 256-bit chaining value. The first block uses the standard initial hash as its chaining value; later blocks use the previous digest. The engine then runs 64 rounds, one per clock. Each round takes schedule word W[t] from an external memory with a one-cycle synchronous read, and the round constant K[t] from a combinational case lookup indexed by the round number.

After the last round, each working variable is added modulo 2^32 to the chaining word it started from. The engine then raises `hash_valid` and holds it until `hash_ack` is seen. After the acknowledge it streams the 256-bit digest as eight 32-bit segments on consecutive cycles, word 0 first, each one tagged with its index.

Schedule expansion, message padding and the sequencing of several blocks belong to the surrounding logic.

Top module: `sha256_round_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the engine clears its state. After that edge, `busy`, `hash_valid`, `seg_valid` and `w_rd` are all 0.
- R2: A `start` sampled while the engine is idle begins a compression. `busy` is high from the next cycle until the cycle after the last segment.
- R3: Schedule reads are synchronous. `w_rd` is high with `w_addr` = t one cycle before W[t] is consumed. During one compression, each address 0 to 63 is read exactly once, in ascending order.
- R4: Each round computes T1 = h + S1(e) + Ch(e,f,g) + K[t] + W[t] and T2 = S0(a) + Maj(a,b,c). The variables then shift down one place (h takes g, g takes f, and so on), with e = d + T1 and a = T1 + T2, all modulo 2^32. Here S0 is the XOR of a rotated right by 2, 13 and 22; S1 is the XOR of e rotated right by 6, 11 and 25; Ch = (e&f)^(~e&g); Maj = (a&b)^(a&c)^(b&c).
- R5: K[t] is the first 32 fraction bits of the cube root of the (t+1)-th prime. Known vectors therefore give the standard digests.
- R6: The digest word i is chain word i plus working variable i, modulo 2^32. Chain word i is `chain_in[255-32*i -: 32]`, so word 0 is variable a. The chain value is captured at the start edge, and later changes on `chain_in` have no effect on the result.
- R7: `hash_valid` rises 66 clock edges after the edge that accepted `start`, and stays high until `hash_ack` is sampled high.
- R8: At the edge where `hash_ack` is sampled high, `hash_valid` falls and `seg_valid` rises. For eight consecutive cycles `seg_idx` then counts 0 to 7 while `seg_data` carries digest word `seg_idx`. `seg_valid` and `hash_valid` are never high together.
- R9: A `start` sampled while `busy` is high is ignored. The timing and the digest of the running compression are unchanged.
- R10: After the last segment the engine is idle, and a `start` held high across that point begins a new compression one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a compression when idle |
| chain_in | input | 256 | Chaining value; word 0 in bits 255:224 |
| busy | output | 1 | Compression or delivery in progress |
| w_rd | output | 1 | Schedule memory read enable |
| w_addr | output | 6 | Schedule memory word address |
| w_data | input | 32 | Schedule word, valid one cycle after the read |
| hash_valid | output | 1 | Digest ready, waiting for acknowledge |
| hash_ack | input | 1 | Acknowledge; starts segment delivery |
| seg_valid | output | 1 | Segment strobe |
| seg_idx | output | 3 | Index of the current segment |
| seg_data | output | 32 | Current 32-bit digest segment |

## Verification
The bench builds the block with its fixed defaults: 64 rounds and eight 32-bit words. With those sizes, full-length known-answer vectors for the padded empty message and for "abc" are in reach, and they exercise every round constant. A behavioural model computes the digest and the expected cycle of every handshake edge, and it is compared against the outputs on every clock. Random chain values and schedules, a start pulse and a chain change in the middle of a run, a late acknowledge and a back-to-back restart test the capture, ignore and restart rules.

// File: rtl/sha256_rnd_pkg.sv
package sha256_rnd_pkg;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 8;
  localparam int NROUNDS = 64;
  localparam int RND_W   = $clog2(NROUNDS);
  localparam int SEG_W   = $clog2(NWORDS);

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NWORDS-1:0] wvec_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRIME, ST_ROUND, ST_FOLD, ST_WAIT, ST_SEND
  } eng_state_t;

  function automatic word_t rotr(word_t x, int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t sum0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t sum1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t choose(word_t x, word_t y, word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t major(word_t x, word_t y, word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction
endpackage

// File: rtl/sha256_kconst.sv
module sha256_kconst
  import sha256_rnd_pkg::*;
(
  input  logic [RND_W-1:0] idx,
  output word_t            k
);
  always_comb begin
    case (idx)
      6'd0:  k = 32'h428a2f98;  6'd1:  k = 32'h71374491;
      6'd2:  k = 32'hb5c0fbcf;  6'd3:  k = 32'he9b5dba5;
      6'd4:  k = 32'h3956c25b;  6'd5:  k = 32'h59f111f1;
      6'd6:  k = 32'h923f82a4;  6'd7:  k = 32'hab1c5ed5;
      6'd8:  k = 32'hd807aa98;  6'd9:  k = 32'h12835b01;
      6'd10: k = 32'h243185be;  6'd11: k = 32'h550c7dc3;
      6'd12: k = 32'h72be5d74;  6'd13: k = 32'h80deb1fe;
      6'd14: k = 32'h9bdc06a7;  6'd15: k = 32'hc19bf174;
      6'd16: k = 32'he49b69c1;  6'd17: k = 32'hefbe4786;
      6'd18: k = 32'h0fc19dc6;  6'd19: k = 32'h240ca1cc;
      6'd20: k = 32'h2de92c6f;  6'd21: k = 32'h4a7484aa;
      6'd22: k = 32'h5cb0a9dc;  6'd23: k = 32'h76f988da;
      6'd24: k = 32'h983e5152;  6'd25: k = 32'ha831c66d;
      6'd26: k = 32'hb00327c8;  6'd27: k = 32'hbf597fc7;
      6'd28: k = 32'hc6e00bf3;  6'd29: k = 32'hd5a79147;
      6'd30: k = 32'h06ca6351;  6'd31: k = 32'h14292967;
      6'd32: k = 32'h27b70a85;  6'd33: k = 32'h2e1b2138;
      6'd34: k = 32'h4d2c6dfc;  6'd35: k = 32'h53380d13;
      6'd36: k = 32'h650a7354;  6'd37: k = 32'h766a0abb;
      6'd38: k = 32'h81c2c92e;  6'd39: k = 32'h92722c85;
      6'd40: k = 32'ha2bfe8a1;  6'd41: k = 32'ha81a664b;
      6'd42: k = 32'hc24b8b70;  6'd43: k = 32'hc76c51a3;
      6'd44: k = 32'hd192e819;  6'd45: k = 32'hd6990624;
      6'd46: k = 32'hf40e3585;  6'd47: k = 32'h106aa070;
      6'd48: k = 32'h19a4c116;  6'd49: k = 32'h1e376c08;
      6'd50: k = 32'h2748774c;  6'd51: k = 32'h34b0bcb5;
      6'd52: k = 32'h391c0cb3;  6'd53: k = 32'h4ed8aa4a;
      6'd54: k = 32'h5b9cca4f;  6'd55: k = 32'h682e6ff3;
      6'd56: k = 32'h748f82ee;  6'd57: k = 32'h78a5636f;
      6'd58: k = 32'h84c87814;  6'd59: k = 32'h8cc70208;
      6'd60: k = 32'h90befffa;  6'd61: k = 32'ha4506ceb;
      6'd62: k = 32'hbef9a3f7;  default: k = 32'hc67178f2;
    endcase
  end
endmodule

// File: rtl/sha256_round_dp.sv
module sha256_round_dp
  import sha256_rnd_pkg::*;
(
  input  wvec_t cur,
  input  word_t k,
  input  word_t w,
  output wvec_t nxt
);
  word_t t1, t2;

  always_comb begin
    t1 = cur[7] + sum1(cur[4]) + choose(cur[4], cur[5], cur[6]) + k + w;
    t2 = sum0(cur[0]) + major(cur[0], cur[1], cur[2]);
    nxt[0] = t1 + t2;
    nxt[1] = cur[0];
    nxt[2] = cur[1];
    nxt[3] = cur[2];
    nxt[4] = cur[3] + t1;
    nxt[5] = cur[4];
    nxt[6] = cur[5];
    nxt[7] = cur[6];
  end
endmodule

// File: rtl/sha256_seg_tx.sv
module sha256_seg_tx
  import sha256_rnd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  wvec_t            dig,
  output logic             seg_valid,
  output logic [SEG_W-1:0] seg_idx,
  output word_t            seg_data
);
  localparam logic [SEG_W-1:0] LAST = SEG_W'(NWORDS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_valid <= 1'b0;
      seg_idx   <= '0;
      seg_data  <= '0;
    end else if (load) begin
      seg_valid <= 1'b1;
      seg_idx   <= '0;
      seg_data  <= dig[0];
    end else if (seg_valid) begin
      if (seg_idx == LAST) begin
        seg_valid <= 1'b0;
      end else begin
        seg_idx  <= seg_idx + 1'b1;
        seg_data <= dig[seg_idx + 1'b1];
      end
    end
  end

  // R8
  seg_step_chk: assert property (@(posedge clk) disable iff (rst)
    seg_valid && seg_idx != LAST |=> seg_valid && seg_idx == $past(seg_idx) + 1'b1);
endmodule

// File: rtl/sha256_round_engine.sv
module sha256_round_engine
  import sha256_rnd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [NWORDS*WORD_W-1:0] chain_in,
  output logic                     busy,
  output logic                     w_rd,
  output logic [RND_W-1:0]         w_addr,
  input  logic [WORD_W-1:0]        w_data,
  output logic                     hash_valid,
  input  logic                     hash_ack,
  output logic                     seg_valid,
  output logic [SEG_W-1:0]         seg_idx,
  output logic [WORD_W-1:0]        seg_data
);
  localparam logic [RND_W-1:0] LAST_RND  = RND_W'(NROUNDS - 1);
  localparam logic [RND_W-1:0] LAST_READ = RND_W'(NROUNDS - 3);
  localparam logic [SEG_W-1:0] LAST_SEG  = SEG_W'(NWORDS - 1);

  eng_state_t       state;
  logic [RND_W-1:0] rnd;
  wvec_t            chain_words, chain_q, work_q, work_nxt, fold, hash_q;
  word_t            kval;
  logic             tx_load;

  for (genvar gi = 0; gi < NWORDS; gi++) begin : g_words
    assign chain_words[gi] = chain_in[WORD_W*(NWORDS-gi)-1 -: WORD_W];
    assign fold[gi]        = chain_q[gi] + work_q[gi];
  end

  sha256_kconst u_kconst (.idx(rnd), .k(kval));

  sha256_round_dp u_round (.cur(work_q), .k(kval), .w(w_data), .nxt(work_nxt));

  assign tx_load = (state == ST_WAIT) && hash_ack;

  sha256_seg_tx u_tx (
    .clk(clk), .rst(rst), .load(tx_load), .dig(hash_q),
    .seg_valid(seg_valid), .seg_idx(seg_idx), .seg_data(seg_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      rnd        <= '0;
      w_rd       <= 1'b0;
      w_addr     <= '0;
      hash_valid <= 1'b0;
      busy       <= 1'b0;
      chain_q    <= '0;
      work_q     <= '0;
      hash_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          chain_q <= chain_words;
          work_q  <= chain_words;
          w_addr  <= '0;
          w_rd    <= 1'b1;
          busy    <= 1'b1;
          state   <= ST_PRIME;
        end
        ST_PRIME: begin
          rnd    <= '0;
          w_addr <= RND_W'(1);
          state  <= ST_ROUND;
        end
        ST_ROUND: begin
          work_q <= work_nxt;
          rnd    <= rnd + 1'b1;
          w_addr <= rnd + RND_W'(2);
          w_rd   <= (rnd <= LAST_READ);
          if (rnd == LAST_RND) state <= ST_FOLD;
        end
        ST_FOLD: begin
          hash_q     <= fold;
          hash_valid <= 1'b1;
          state      <= ST_WAIT;
        end
        ST_WAIT: if (hash_ack) begin
          hash_valid <= 1'b0;
          state      <= ST_SEND;
        end
        ST_SEND: if (seg_valid && seg_idx == LAST_SEG) begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  hv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hash_valid && !hash_ack |=> hash_valid);

  // R3
  rd_seq_chk: assert property (@(posedge clk) disable iff (rst)
    w_rd && $past(w_rd) |-> w_addr == $past(w_addr) + 1'b1);

  // R8
  hv_seg_excl_chk: assert property (@(posedge clk) disable iff (rst)
    hash_valid |-> !seg_valid);

  // R2
  busy_span_chk: assert property (@(posedge clk) disable iff (rst)
    (hash_valid || seg_valid || w_rd) |-> busy);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start && !seg_valid |=> busy);
endmodule

// File: tb/test_sha256_round_engine.sv
`timescale 1ns/1ps
module test_sha256_round_engine;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [255:0] chain_in = '0;
  logic         hash_ack = 1'b0;
  logic [31:0]  w_data = '0;
  logic         busy, w_rd, hash_valid, seg_valid;
  logic [5:0]   w_addr;
  logic [2:0]   seg_idx;
  logic [31:0]  seg_data;

  always #2.5 clk = ~clk;

  sha256_round_engine i_sha256_round_engine (
    .clk(clk), .rst(rst), .start(start), .chain_in(chain_in), .busy(busy),
    .w_rd(w_rd), .w_addr(w_addr), .w_data(w_data), .hash_valid(hash_valid),
    .hash_ack(hash_ack), .seg_valid(seg_valid), .seg_idx(seg_idx), .seg_data(seg_data)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  localparam logic [255:0] IV = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;

  logic [31:0] wmem [64];
  int          rdcnt [64];
  logic [31:0] kref [64];
  logic [31:0] got [8];
  logic [31:0] m_dig [8];
  int          m_mode = 0;
  int          m_cnt = 0;
  bit          m_busy = 0, m_hv = 0, m_sv = 0;
  int          m_idx = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(logic [31:0] x, int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  task automatic ref_compress(input logic [255:0] ch);
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    for (int i = 0; i < 8; i++) v[i] = ch[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25)) +
           ((v[4] & v[5]) ^ (~v[4] & v[6])) + kref[t] + wmem[t];
      t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22)) +
           ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      for (int j = 7; j > 0; j--) v[j] = v[j-1];
      v[4] = v[4] + t1;
      v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) m_dig[i] = ch[255-32*i -: 32] + v[i];
  endtask

  task automatic expand();
    logic [31:0] s0, s1;
    for (int t = 16; t < 64; t++) begin
      s0 = rr(wmem[t-15],7) ^ rr(wmem[t-15],18) ^ (wmem[t-15] >> 3);
      s1 = rr(wmem[t-2],17) ^ rr(wmem[t-2],19) ^ (wmem[t-2] >> 10);
      wmem[t] = s1 + wmem[t-7] + s0 + wmem[t-16];
    end
  endtask

  // schedule memory with one-cycle synchronous read
  always @(posedge clk) begin
    cyc++;
    if (w_rd) begin
      w_data <= wmem[w_addr];
      rdcnt[w_addr]++;
    end
  end

  // behavioural cycle model
  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_busy = 0; m_hv = 0; m_sv = 0; m_idx = 0; m_cnt = 0;
    end else begin
      case (m_mode)
        0: if (start) begin ref_compress(chain_in); m_busy = 1; m_cnt = 0; m_mode = 1; end
        1: begin m_cnt++; if (m_cnt == 66) begin m_hv = 1; m_mode = 2; end end
        2: if (hash_ack) begin m_hv = 0; m_sv = 1; m_idx = 0; m_mode = 3; end
        default: if (m_idx == 7) begin m_sv = 0; m_busy = 0; m_mode = 0; end
                 else m_idx++;
      endcase
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 busy", 32'(busy), 32'(m_busy));
      chk("R7 hash_valid", 32'(hash_valid), 32'(m_hv));
      chk("R8 seg_valid", 32'(seg_valid), 32'(m_sv));
      if (seg_valid && m_sv) begin
        chk("R8 seg_idx", 32'(seg_idx), 32'(m_idx));
        chk("R8 seg_data", seg_data, m_dig[m_idx]);
        got[seg_idx] = seg_data;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic do_start(input logic [255:0] ch);
    for (int i = 0; i < 64; i++) rdcnt[i] = 0;
    @(negedge clk); chain_in = ch; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_hash(int delay);
    while (!hash_valid) @(negedge clk);
    repeat (delay) @(negedge clk);
    hash_ack = 1'b1;
    @(negedge clk); hash_ack = 1'b0;
    repeat (9) @(negedge clk);
  endtask

  task automatic check_reads();
    for (int i = 0; i < 64; i++) chk($sformatf("R3 reads of addr %0d", i), 32'(rdcnt[i]), 32'd1);
  endtask

  task automatic check_digest(string tag, logic [255:0] exp);
    for (int i = 0; i < 8; i++) chk(tag, got[i], exp[255-32*i -: 32]);
  endtask

  initial begin
    int p, n;
    bit isp;
    real r, fr;
    logic [255:0] rch;
    n = 0; p = 2;
    while (n < 64) begin
      isp = 1;
      for (int d = 2; d * d <= p; d++) if (p % d == 0) isp = 0;
      if (isp) begin
        r  = $pow(real'(p), 1.0 / 3.0);
        fr = r - $floor(r);
        kref[n] = 32'(longint'($floor(fr * 4294967296.0)));
        n++;
      end
      p++;
    end

    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 hash_valid", 32'(hash_valid), 0);
    chk("R1 seg_valid", 32'(seg_valid), 0);
    chk("R1 w_rd", 32'(w_rd), 0);
    rst = 1'b0;

    // R5 known answer: "abc"
    for (int i = 0; i < 64; i++) wmem[i] = '0;
    wmem[0] = 32'h61626380; wmem[15] = 32'h00000018;
    expand();
    do_start(IV);
    finish_hash(0);
    check_digest("R5 abc digest",
      256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);
    check_reads();

    // R5 known answer: empty message
    for (int i = 0; i < 64; i++) wmem[i] = '0;
    wmem[0] = 32'h80000000;
    expand();
    do_start(IV);
    finish_hash(3);
    check_digest("R5 empty digest",
      256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855);

    // R4 R6 R9: random chain and schedule, start and chain change mid-run
    for (int i = 0; i < 64; i++) wmem[i] = $urandom;
    for (int i = 0; i < 8; i++) rch[255-32*i -: 32] = $urandom;
    do_start(rch);
    repeat (10) @(negedge clk);
    chain_in = ~rch; start = 1'b1;
    @(negedge clk); start = 1'b0;
    ref_compress(rch);
    finish_hash(5);
    check_digest("R4 R6 R9 random digest", {m_dig[0], m_dig[1], m_dig[2], m_dig[3],
                                           m_dig[4], m_dig[5], m_dig[6], m_dig[7]});
    check_reads();

    // R10 back-to-back: start held high across the return to idle
    for (int i = 0; i < 8; i++) rch[255-32*i -: 32] = $urandom;
    do_start(rch);
    while (!hash_valid) @(negedge clk);
    hash_ack = 1'b1;
    @(negedge clk); hash_ack = 1'b0;
    for (int i = 0; i < 64; i++) rdcnt[i] = 0;
    chain_in = IV; start = 1'b1;
    repeat (9) @(negedge clk);
    start = 1'b0;
    chk("R10 busy after restart", 32'(busy), 1);
    finish_hash(1);
    check_reads();

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule